// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store Processor Core

This block is a small processor core. Its instructions are 16 bits wide, and it has eight general registers of 16 bits each. A Moore control machine takes every instruction through a fixed series of one-cycle states. The core has a single memory port, and instructions and data share it. The port has an address, a read strobe, a write strobe, write data and read data. The memory lives outside the core. It returns read data one clock after the cycle in which the read strobe and address are presented.

Inside the core are the following parts:
- the program counter;
- the instruction register;
- two operand latches;
- a register file with two read ports and one write port;
- one shared ALU.

The ALU also computes the incremented program counter during fetch, and the effective addresses. The instruction word arrives on the read data in the decode cycle. Decode uses it directly to pick the registers to read and the next state, and the instruction register captures it at the end of that cycle.

States and transitions:
- FETCH: read at PC, PC <= PC + 1. Always goes to DECODE.
- DECODE: capture the instruction and latch both operands. Goes to one of:
  - ALU_R for R-type with funct 0..4;
  - ADDI;
  - LOAD_REQ for lw;
  - STORE for sw;
  - BRANCH for beq with equal operands;
  - JUMP for j;
  - HALT for opcode 7;
  - FETCH for everything else (a beq that is not taken, opcode 6, R-type with funct 5..15).
- LOAD_REQ: read at the effective address. Goes to LOAD_WB.
- LOAD_WB: write the read data to rt. Goes to FETCH.
- ALU_R, ADDI, STORE, BRANCH and JUMP each take one cycle and go to FETCH.
- HALT: stays in HALT until reset.

Top module: `cpu16_core`

## Requirements
- R1: While reset is active (rst_n low) and afterwards, the following hold. PC is 0 and all eight registers are 0. The control machine is in FETCH, so the first cycle after release reads address 0 and writes nothing.
- R2: Every instruction starts with one FETCH cycle. That cycle drives mem_rd high and mem_addr equal to PC, and PC becomes PC + 1. The next sequential instruction is therefore fetched at the next address.
- R3: Instruction fields are as follows. opcode is [15:13]. rs is [12:10] and rt is [9:7]. For R-type (opcode 0) rd is [6:4] and funct is [3:0]. Loads, stores, addi and beq use a 7-bit offset in [6:0]. j (opcode 5) uses a 13-bit target in [12:0]. A valid R-type instruction takes 3 cycles: FETCH, DECODE, ALU_R.
- R4: The R-type funct codes are 0 for rd = rs + rt, 1 for rd = rs - rt (modulo 2^16), 2 for rd = rs & rt, 3 for rd = rs | rt, and 4 for rd = 1 if rs < rt as signed two's complement, else 0.
- R5: addi (opcode 4) writes rs + sign-extended offset to rt in 3 cycles.
- R6: lw (opcode 1) reads memory at rs + sign-extended offset and writes the word to rt. It takes 4 cycles, and its data read follows the fetch read by two cycles.
- R7: sw (opcode 2) asserts mem_wr for one cycle with mem_addr = rs + sign-extended offset and mem_wdata = rt. It takes 3 cycles. mem_rd and mem_wr are never high together.
- R8: beq (opcode 3) behaves in one of two ways:
  - When rs equals rt, the PC becomes the incremented PC plus the sign-extended offset, in 3 cycles.
  - Otherwise execution continues at the next address after 2 cycles.
- R9: j (opcode 5) loads the PC with the 13-bit target, zero-extended to 16 bits, in 3 cycles.
- R10: halt (opcode 7) stops execution. After its fetch, the core makes no further memory read or write until reset.
- R11: The following instructions change no register and no memory, and return to FETCH after 2 cycles:
  - opcode 6;
  - R-type instructions with funct 5..15.
- R12: Register 0 is an ordinary register that can be written and read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Word address: PC in fetch, effective address in load/store |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata one cycle later |
| mem_wr | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 16 | Store data (rt operand) |
| mem_rdata | input | 16 | Read data from the memory, one cycle after the read strobe |

## Verification
A wrong control state shows up on the memory port within one or two cycles. A missed or extra state moves every later fetch address and cycle index, and the halt fetch then lands on a cycle other than the one computed for the program. A wrong PC update shows up as a fetch at an unexpected address on the very next FETCH. A bad ALU result or register write, or a wrong destination choice, stays hidden until a later sw places the register on mem_wdata. For that reason each test program stores every result it produces, together with a sentinel word placed behind the halt instruction.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

    localparam int XLEN   = 16;
    localparam int NREGS  = 8;
    localparam int RIDX   = $clog2(NREGS);
    localparam int OFFW   = 7;
    localparam int TGTW   = 13;

    localparam logic [2:0] OPC_RTYPE = 3'd0;
    localparam logic [2:0] OPC_LOAD  = 3'd1;
    localparam logic [2:0] OPC_STORE = 3'd2;
    localparam logic [2:0] OPC_BEQ   = 3'd3;
    localparam logic [2:0] OPC_ADDI  = 3'd4;
    localparam logic [2:0] OPC_JUMP  = 3'd5;
    localparam logic [2:0] OPC_HALT  = 3'd7;

    localparam logic [3:0] FUNCT_LAST = 4'd4;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_ALU_R,
        ST_ADDI,
        ST_LOAD_REQ,
        ST_LOAD_WB,
        ST_STORE,
        ST_BRANCH,
        ST_JUMP,
        ST_HALT
    } cpu_state_t;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_fn_t;

    typedef enum logic [1:0] {
        BSRC_ONE,
        BSRC_REGB,
        BSRC_OFFS
    } bsrc_t;

    typedef struct packed {
        logic    pc_ld;
        logic    pc_from_tgt;
        logic    ir_ld;
        logic    opnd_ld;
        logic    rf_we;
        logic    wb_from_mem;
        logic    dst_is_rd;
        logic    a_is_pc;
        bsrc_t   bsrc;
        logic    fn_from_ir;
        logic    rd_en;
        logic    wr_en;
        logic    addr_is_ea;
    } ctrl_t;

endpackage

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  alu_fn_t           fn,
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    output logic [WIDTH-1:0]  y
);

    always_comb begin
        unique case (fn)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rsel_a,
    input  logic [AW-1:0]     rsel_b,
    output logic [WIDTH-1:0]  rval_a,
    output logic [WIDTH-1:0]  rval_b,
    input  logic              wen,
    input  logic [AW-1:0]     wsel,
    input  logic [WIDTH-1:0]  wval
);

    logic [WIDTH-1:0] bank [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                bank[i] <= '0;
            end
        end else if (wen) begin
            bank[wsel] <= wval;
        end
    end

    assign rval_a = bank[rsel_a];
    assign rval_b = bank[rsel_b];

    // R12: a write to any index, index 0 included, is visible on the next read
    a_r12_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && rsel_a == wsel) |=> (rval_a == $past(wval)));

endmodule

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
    import cpu16_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  opc,
    input  logic [3:0]  funct,
    input  logic        opnd_eq,
    output cpu_state_t  state,
    output ctrl_t       ctl
);

    cpu_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= nxt;
    end

    always_comb begin
        nxt = ST_FETCH;
        unique case (state)
            ST_FETCH:    nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (opc)
                    OPC_RTYPE: nxt = (funct <= FUNCT_LAST) ? ST_ALU_R : ST_FETCH;
                    OPC_LOAD:  nxt = ST_LOAD_REQ;
                    OPC_STORE: nxt = ST_STORE;
                    OPC_BEQ:   nxt = opnd_eq ? ST_BRANCH : ST_FETCH;
                    OPC_ADDI:  nxt = ST_ADDI;
                    OPC_JUMP:  nxt = ST_JUMP;
                    OPC_HALT:  nxt = ST_HALT;
                    default:   nxt = ST_FETCH;
                endcase
            end
            ST_LOAD_REQ: nxt = ST_LOAD_WB;
            ST_HALT:     nxt = ST_HALT;
            default:     nxt = ST_FETCH;
        endcase
    end

    always_comb begin
        ctl      = '0;
        ctl.bsrc = BSRC_ONE;
        unique case (state)
            ST_FETCH: begin
                ctl.rd_en   = 1'b1;
                ctl.a_is_pc = 1'b1;
                ctl.bsrc    = BSRC_ONE;
                ctl.pc_ld   = 1'b1;
            end
            ST_DECODE: begin
                ctl.ir_ld   = 1'b1;
                ctl.opnd_ld = 1'b1;
            end
            ST_ALU_R: begin
                ctl.bsrc       = BSRC_REGB;
                ctl.fn_from_ir = 1'b1;
                ctl.rf_we      = 1'b1;
                ctl.dst_is_rd  = 1'b1;
            end
            ST_ADDI: begin
                ctl.bsrc  = BSRC_OFFS;
                ctl.rf_we = 1'b1;
            end
            ST_LOAD_REQ: begin
                ctl.bsrc       = BSRC_OFFS;
                ctl.rd_en      = 1'b1;
                ctl.addr_is_ea = 1'b1;
            end
            ST_LOAD_WB: begin
                ctl.rf_we       = 1'b1;
                ctl.wb_from_mem = 1'b1;
            end
            ST_STORE: begin
                ctl.bsrc       = BSRC_OFFS;
                ctl.wr_en      = 1'b1;
                ctl.addr_is_ea = 1'b1;
            end
            ST_BRANCH: begin
                ctl.a_is_pc = 1'b1;
                ctl.bsrc    = BSRC_OFFS;
                ctl.pc_ld   = 1'b1;
            end
            ST_JUMP: begin
                ctl.pc_ld       = 1'b1;
                ctl.pc_from_tgt = 1'b1;
            end
            default: ;
        endcase
    end

    // R3: fetch is always followed by decode
    a_r3_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_DECODE));

    // R6: a load request is always followed by its write-back
    a_r6_load_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD_REQ) |=> (state == ST_LOAD_WB));

    // R11: opcode 6 goes straight back to fetch
    a_r11_unused_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && opc == 3'd6) |=> (state == ST_FETCH));

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
    import cpu16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [XLEN-1:0]   mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata
);

    cpu_state_t       state;
    ctrl_t            ctl;
    logic [XLEN-1:0]  pc_q;
    logic [XLEN-1:0]  ir_q;
    logic [XLEN-1:0]  opa_q;
    logic [XLEN-1:0]  opb_q;
    logic [XLEN-1:0]  instr;
    logic [XLEN-1:0]  rf_a;
    logic [XLEN-1:0]  rf_b;
    logic [XLEN-1:0]  alu_a;
    logic [XLEN-1:0]  alu_b;
    logic [XLEN-1:0]  alu_y;
    logic [XLEN-1:0]  offs_x;
    logic [XLEN-1:0]  tgt_x;
    logic [XLEN-1:0]  wb_val;
    logic [RIDX-1:0]  wb_sel;
    alu_fn_t          alu_fn;

    // The instruction word is on the read bus during decode, latched after it
    assign instr  = (state == ST_DECODE) ? mem_rdata : ir_q;
    assign offs_x = {{(XLEN-OFFW){ir_q[OFFW-1]}}, ir_q[OFFW-1:0]};
    assign tgt_x  = {{(XLEN-TGTW){1'b0}}, ir_q[TGTW-1:0]};

    cpu16_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .opc     (instr[15:13]),
        .funct   (instr[3:0]),
        .opnd_eq (rf_a == rf_b),
        .state   (state),
        .ctl     (ctl)
    );

    cpu16_regfile #(.WIDTH(XLEN), .DEPTH(NREGS)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .rsel_a (instr[12:10]),
        .rsel_b (instr[9:7]),
        .rval_a (rf_a),
        .rval_b (rf_b),
        .wen    (ctl.rf_we),
        .wsel   (wb_sel),
        .wval   (wb_val)
    );

    always_comb begin
        alu_a = ctl.a_is_pc ? pc_q : opa_q;
        unique case (ctl.bsrc)
            BSRC_REGB: alu_b = opb_q;
            BSRC_OFFS: alu_b = offs_x;
            default:   alu_b = {{(XLEN-1){1'b0}}, 1'b1};
        endcase
        alu_fn = ctl.fn_from_ir ? alu_fn_t'(ir_q[2:0]) : ALU_ADD;
    end

    cpu16_alu #(.WIDTH(XLEN)) u_alu (
        .fn (alu_fn),
        .a  (alu_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    assign wb_sel = ctl.dst_is_rd ? ir_q[6:4] : ir_q[9:7];
    assign wb_val = ctl.wb_from_mem ? mem_rdata : alu_y;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= '0;
            opa_q <= '0;
            opb_q <= '0;
        end else begin
            if (ctl.pc_ld)   pc_q  <= ctl.pc_from_tgt ? tgt_x : alu_y;
            if (ctl.ir_ld)   ir_q  <= mem_rdata;
            if (ctl.opnd_ld) begin
                opa_q <= rf_a;
                opb_q <= rf_b;
            end
        end
    end

    assign mem_addr  = ctl.addr_is_ea ? alu_y : pc_q;
    assign mem_rd    = ctl.rd_en;
    assign mem_wr    = ctl.wr_en;
    assign mem_wdata = opb_q;

    // R2: each fetch advances the PC by one
    a_r2_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (pc_q == $past(pc_q) + 16'd1));

    // R2: the PC does not move during decode
    a_r2_pc_hold_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE) |=> $stable(pc_q));

    // R7: the two strobes never overlap
    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R10: once halted, the port stays idle
    a_r10_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (state == ST_HALT && !mem_rd && !mem_wr));

endmodule

// File: tb/cpu16_core_test.sv
module cpu16_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    cpu16_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // Memory model: one-cycle synchronous read, plus a load path for the bench
    logic [15:0] mem [256];
    logic        ld_we = 1'b0;
    logic        ld_clr = 1'b0;
    logic [7:0]  ld_a = '0;
    logic [15:0] ld_d = '0;

    always @(posedge clk) begin
        if (ld_clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
        end else if (ld_we) begin
            mem[ld_a] <= ld_d;
        end else if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    // Port monitor
    int          cyc;
    int          last_acc;
    int          n_wr;
    int          n_rd;
    logic [15:0] trace [64];

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; last_acc = -1; n_wr = 0; n_rd = 0;
        end else begin
            if (mem_rd) begin
                if (n_rd < 64) trace[n_rd] = mem_addr;
                n_rd++;
            end
            if (mem_wr) n_wr++;
            if (mem_rd || mem_wr) last_acc = cyc;
            cyc++;
        end
    end

    function automatic logic [15:0] enc_r(int rs, int rt, int rd, int fn);
        return {3'd0, 3'(rs), 3'(rt), 3'(rd), 4'(fn)};
    endfunction
    function automatic logic [15:0] enc_i(int op, int rs, int rt, int off);
        return {3'(op), 3'(rs), 3'(rt), 7'(off)};
    endfunction
    function automatic logic [15:0] enc_j(int op, int tgt);
        return {3'(op), 13'(tgt)};
    endfunction

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        @(negedge clk); ld_clr = 1'b1;
        @(negedge clk); ld_clr = 1'b0;
    endtask

    task automatic put(int a, logic [15:0] d);
        ld_a = 8'(a); ld_d = d; ld_we = 1'b1;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic run_to_halt();
        @(posedge clk); #1 rst_n = 1'b1;
        for (int k = 0; k < 2000; k++) begin
            @(posedge clk);
            if (cyc > last_acc + 12) break;
        end
    endtask

    // R1: port state while held in reset
    task automatic test_reset();
        rst_n = 1'b0;
        clear_mem();
        @(negedge clk);
        check16("R1 rd during reset", 16'(mem_rd), 16'h1);
        check16("R1 addr during reset", mem_addr, 16'h0000);
        check16("R1 wr during reset", 16'(mem_wr), 16'h0);
    endtask

    // R2 R3 R4 R5 R7 R10 R12: arithmetic program with stores and a sentinel
    task automatic test_alu();
        rst_n = 1'b0;
        clear_mem();
        @(negedge clk);
        put(0,  enc_i(4, 0, 1, 7));
        put(1,  enc_i(4, 0, 2, -3));
        put(2,  enc_r(1, 2, 3, 0));
        put(3,  enc_r(1, 2, 4, 1));
        put(4,  enc_r(1, 2, 5, 2));
        put(5,  enc_r(1, 2, 6, 3));
        put(6,  enc_r(2, 1, 7, 4));
        put(7,  enc_i(2, 0, 3, 40));
        put(8,  enc_i(2, 0, 4, 41));
        put(9,  enc_i(2, 0, 5, 42));
        put(10, enc_i(2, 0, 6, 43));
        put(11, enc_i(2, 0, 7, 44));
        put(12, enc_r(1, 2, 7, 4));
        put(13, enc_i(2, 0, 7, 45));
        put(14, enc_i(4, 0, 0, 3));
        put(15, enc_i(2, 0, 0, 43));
        put(16, enc_j(7, 0));
        put(17, enc_i(2, 0, 1, 44));
        put(47, 16'hDEAD);
        run_to_halt();
        check16("R4 add", mem[40], 16'h0004);
        check16("R4 sub", mem[41], 16'h000A);
        check16("R4 and", mem[42], 16'h0005);
        check16("R4 or", mem[43], 16'hFFFF);
        check16("R4 slt true", mem[44], 16'h0001);
        check16("R4 slt false", mem[45], 16'h0000);
        check16("R12 r0 written", mem[46], 16'h0003);
        check16("R10 sentinel untouched", mem[47], 16'hDEAD);
        check16("R3 R5 R7 halt fetch cycle", 16'(last_acc), 16'd48);
        check16("R7 store count", 16'(n_wr), 16'd7);
        check16("R10 read count", 16'(n_rd), 16'd17);
        check16("R2 first fetch", trace[0], 16'h0000);
        check16("R2 second fetch", trace[1], 16'h0001);
        check16("R2 third fetch", trace[2], 16'h0002);
    endtask

    // R1 R6 R8 R9 R11: loads, branches, jump and no-ops
    task automatic test_flow();
        logic [15:0] exp_tr [14];
        exp_tr = '{16'd0, 16'd1, 16'd50, 16'd2, 16'd51, 16'd3, 16'd6,
                   16'd7, 16'd8, 16'd9, 16'd20, 16'd21, 16'd22, 16'd23};
        rst_n = 1'b0;
        clear_mem();
        @(negedge clk);
        put(0,  enc_i(4, 0, 1, 50));
        put(1,  enc_i(1, 1, 2, 0));
        put(2,  enc_i(1, 1, 3, 1));
        put(3,  enc_i(3, 2, 2, 2));
        put(4,  enc_i(4, 0, 4, 1));
        put(5,  enc_i(4, 0, 4, 2));
        put(6,  enc_i(3, 2, 3, 5));
        put(7,  enc_i(6, 1, 2, 5));
        put(8,  enc_r(1, 1, 2, 9));
        put(9,  enc_j(5, 20));
        put(10, enc_i(4, 0, 2, 0));
        put(20, enc_i(2, 1, 2, 10));
        put(21, enc_i(2, 1, 3, 11));
        put(22, enc_i(2, 1, 4, 12));
        put(23, enc_j(7, 0));
        put(50, 16'h1234);
        put(51, 16'h00AA);
        run_to_halt();
        check16("R6 R11 loaded r2 kept", mem[60], 16'h1234);
        check16("R6 loaded r3", mem[61], 16'h00AA);
        check16("R1 R8 r4 cleared and skipped", mem[62], 16'h0000);
        check16("R6 R8 R9 R11 halt fetch cycle", 16'(last_acc), 16'd32);
        check16("R6 read count", 16'(n_rd), 16'd14);
        for (int i = 0; i < 14; i++) begin
            check16($sformatf("R1 R6 R8 R9 trace %0d", i), trace[i], exp_tr[i]);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected halt");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        test_reset();
        test_alu();
        test_flow();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule